// File: doc/BRIEF.md
# Masked Vector Multiply-Accumulate Unit

This block updates a packed destination vector in place: every active element takes its old value plus the product of two source elements. The first multiplicand always comes from source vector A. The second comes either from source vector B, element by element, or from a single scalar that is applied to every element. Arithmetic runs at the selected element width (8, 16, 32 or 64 bits). Only the low element-width bits are kept, so overflow wraps and raises no flag. Signed and unsigned operands therefore give the same bits.

Each element is gated by a per-element enable bit and by the vector length. An element that is switched off, or that lies at or beyond the vector length, either keeps its old value or is overwritten with all ones, as two policy flags select.

The unit loads all operands and controls on a `start` pulse while idle. It then writes one element slot per cycle, pulses `done` once, and holds the result until the next accepted start.

Top module: `vmac_unit`

## Requirements
- R1: The element-width code `ew` selects 0=8, 1=16, 2=32 and 3=64 bits. The vector holds REG_W/width element slots. Element i occupies bits [i*width +: width], counted from the LSB.
- R2: In an active element, the new value is old + A[i]*B[i], truncated to the element width. Overflow wraps silently.
- R3: With `use_scalar`=1, the low element-width bits of `scalar` replace B[i] for every element. Higher scalar bits have no effect.
- R4: With `unmasked`=0, bit i of `elem_en` enables element i. With `unmasked`=1, every element below `vl` is active whatever `elem_en` holds.
- R5: A disabled element below `vl` keeps its old value when `mask_agn`=0 and becomes all ones when `mask_agn`=1.
- R6: An element at index >= `vl` keeps its old value when `tail_agn`=0 and becomes all ones when `tail_agn`=1.
- R7: With `vl`=0, the whole destination is returned unchanged, whatever the policy flags are.
- R8: After the edge that accepts `start`, `busy` is high for exactly N cycles, where N is the slot count. `done` is high for exactly one cycle, in the cycle after the last slot is written, while `busy` is low.
- R9: While idle, `vd_out` holds its value until the next accepted start. A `start` that arrives while `busy` is high is ignored.
- R10: After reset, `busy`=0, `done`=0 and `vd_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| ew | input | 2 | Element-width code |
| vl | input | VL_W (5) | Vector length in elements |
| unmasked | input | 1 | 1: ignore `elem_en` |
| use_scalar | input | 1 | 1: second multiplicand is `scalar` |
| tail_agn | input | 1 | Tail policy: 0 keep, 1 all ones |
| mask_agn | input | 1 | Disabled-element policy: 0 keep, 1 all ones |
| vd_in | input | REG_W (128) | Old destination vector |
| src_a | input | REG_W (128) | First multiplicand vector |
| src_b | input | REG_W (128) | Second multiplicand vector |
| scalar | input | 64 | Broadcast multiplicand |
| elem_en | input | MAX_SLOTS (16) | Per-element enable bits |
| vd_out | output | REG_W (128) | Result vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong slot index or shift amount writes a result into the neighbouring element. That shows up in `vd_out` at the next `done`, so the bench compares the whole vector against a model at every completion, across all four widths. A wrong slot count or sequencer state moves `done` earlier or later than N cycles after the start. The bench counts the cycles exactly, so the error shows in the same operation. A wrongly applied policy or gate leaves the wrong element old, all ones or computed, and that is visible at the first completion that uses the pattern.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_e;

  function automatic int ew_bits(ew_e code);
    return 8 << code;
  endfunction

  function automatic logic [63:0] ew_mask(ew_e code);
    case (code)
      EW8:     return 64'h0000_0000_0000_00FF;
      EW16:    return 64'h0000_0000_0000_FFFF;
      EW32:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/vmac_lane.sv
module vmac_lane
  import vmac_pkg::*;
(
  input  ew_e         ew,
  input  logic [63:0] old_el,
  input  logic [63:0] mul_a,
  input  logic [63:0] mul_b,
  input  logic        en_bit,
  input  logic        tail,
  input  logic        vl_zero,
  input  logic        mask_agn,
  input  logic        tail_agn,
  output logic [63:0] new_el
);
  logic [63:0] emask;
  logic [63:0] mac;

  assign emask = ew_mask(ew);
  assign mac   = old_el + (mul_a & emask) * (mul_b & emask);

  always_comb begin
    if (vl_zero)      new_el = old_el;
    else if (tail)    new_el = tail_agn ? emask : old_el;
    else if (!en_bit) new_el = mask_agn ? emask : old_el;
    else              new_el = mac & emask;
  end
endmodule

// File: rtl/vmac_seq.sv
module vmac_seq #(
  parameter int MAX_SLOTS = 16,
  localparam int IDX_W = $clog2(MAX_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic [IDX_W:0]   slots,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  logic             busy_d, done_d;
  logic [IDX_W-1:0] idx_d;
  logic             last;

  assign last = ({1'b0, idx} == slots - (IDX_W+1)'(1));

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    done_d = 1'b0;
    if (start_acc) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      busy <= busy_d;
      idx  <= idx_d;
      done <= done_d;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, idx} < slots)); // R1
endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
  import vmac_pkg::*;
#(
  parameter int REG_W = 128,
  localparam int MAX_SLOTS = REG_W / 8,
  localparam int IDX_W = $clog2(MAX_SLOTS),
  localparam int VL_W = $clog2(MAX_SLOTS + 1),
  localparam int SH_W = $clog2(REG_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           ew,
  input  logic [VL_W-1:0]      vl,
  input  logic                 unmasked,
  input  logic                 use_scalar,
  input  logic                 tail_agn,
  input  logic                 mask_agn,
  input  logic [REG_W-1:0]     vd_in,
  input  logic [REG_W-1:0]     src_a,
  input  logic [REG_W-1:0]     src_b,
  input  logic [63:0]          scalar,
  input  logic [MAX_SLOTS-1:0] elem_en,
  output logic [REG_W-1:0]     vd_out,
  output logic                 busy,
  output logic                 done
);
  // captured operation
  logic [REG_W-1:0]     res_q, res_d, a_q, b_q;
  logic [63:0]          sc_q;
  logic [MAX_SLOTS-1:0] en_q;
  ew_e                  ew_q;
  logic [VL_W-1:0]      vl_q;
  logic                 unm_q, vx_q, ta_q, ma_q;

  logic                 start_acc;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W:0]       slots;
  logic [SH_W-1:0]      shamt;
  logic [63:0]          emask, old_el, a_el, b_el, new_el;
  logic [REG_W-1:0]     old_sh, a_sh, b_sh;

  assign start_acc = start & ~busy;
  assign slots     = (IDX_W+1)'(REG_W / ew_bits(ew_q));
  assign shamt     = SH_W'(int'(idx) * ew_bits(ew_q));
  assign emask     = ew_mask(ew_q);

  assign old_sh = res_q >> shamt;
  assign a_sh   = a_q >> shamt;
  assign b_sh   = b_q >> shamt;
  assign old_el = old_sh[63:0] & emask;
  assign a_el   = a_sh[63:0];
  assign b_el   = vx_q ? sc_q : b_sh[63:0];

  vmac_seq #(.MAX_SLOTS(MAX_SLOTS)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_acc (start_acc),
    .slots     (slots),
    .busy      (busy),
    .idx       (idx),
    .done      (done)
  );

  vmac_lane i_lane (
    .ew       (ew_q),
    .old_el   (old_el),
    .mul_a    (a_el),
    .mul_b    (b_el),
    .en_bit   (unm_q | en_q[idx]),
    .tail     (VL_W'(idx) >= vl_q),
    .vl_zero  (vl_q == '0),
    .mask_agn (ma_q),
    .tail_agn (ta_q),
    .new_el   (new_el)
  );

  always_comb begin
    res_d = res_q;
    if (start_acc) res_d = vd_in;
    else if (busy) res_d = (res_q & ~(REG_W'(emask) << shamt))
                         | (REG_W'(new_el) << shamt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      sc_q  <= '0;
      en_q  <= '0;
      ew_q  <= EW8;
      vl_q  <= '0;
      unm_q <= 1'b0;
      vx_q  <= 1'b0;
      ta_q  <= 1'b0;
      ma_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      if (start_acc) begin
        a_q   <= src_a;
        b_q   <= src_b;
        sc_q  <= scalar;
        en_q  <= elem_en;
        ew_q  <= ew_e'(ew);
        vl_q  <= vl;
        unm_q <= unmasked;
        vx_q  <= use_scalar;
        ta_q  <= tail_agn;
        ma_q  <= mask_agn;
      end
    end
  end

  assign vd_out = res_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(vd_out)); // R9
  AST_VL_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vl_q == '0) |=> $stable(vd_out)); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(vl_q)); // R9
endmodule

// File: tb/test_vmac_unit.sv
module test_vmac_unit;
  localparam int REG_W = 128;
  localparam int MS = REG_W / 8;

  logic clk, rst_n, start, unmasked, use_scalar, tail_agn, mask_agn;
  logic [1:0] ew;
  logic [4:0] vl;
  logic [REG_W-1:0] vd_in, src_a, src_b, vd_out;
  logic [63:0] scalar;
  logic [MS-1:0] elem_en;
  logic busy, done;
  int checks = 0, errors = 0;

  vmac_unit #(.REG_W(REG_W)) i_vmac_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .ew(ew), .vl(vl),
    .unmasked(unmasked), .use_scalar(use_scalar), .tail_agn(tail_agn),
    .mask_agn(mask_agn), .vd_in(vd_in), .src_a(src_a), .src_b(src_b),
    .scalar(scalar), .elem_en(elem_en), .vd_out(vd_out), .busy(busy), .done(done)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic ok, logic [REG_W-1:0] got, logic [REG_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [REG_W-1:0] model(logic [REG_W-1:0] d, logic [REG_W-1:0] a,
      logic [REG_W-1:0] b, logic [63:0] s, logic [MS-1:0] m, int code, int len,
      logic unm, logic vx, logic ta, logic ma);
    int w = 8 << code;
    int n = REG_W / w;
    logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [REG_W-1:0] r = d;
    for (int i = 0; i < n; i++) begin
      logic [63:0] o = 64'((d >> (i*w))) & msk;
      logic [63:0] x = 64'((a >> (i*w))) & msk;
      logic [63:0] y = vx ? (s & msk) : (64'((b >> (i*w))) & msk);
      logic [63:0] v;
      if (len == 0) v = o;
      else if (i >= len) v = ta ? msk : o;
      else if (!unm && !m[i]) v = ma ? msk : o;
      else v = (o + x * y) & msk;
      r = (r & ~(REG_W'(msk) << (i*w))) | (REG_W'(v) << (i*w));
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // runs one operation, checks timing (R8) and the result
  task automatic run(string req, int code, int len, logic unm, logic vx, logic ta, logic ma);
    logic [REG_W-1:0] exp;
    int cnt = 0;
    int n = REG_W / (8 << code);
    @(negedge clk);
    ew = 2'(code); vl = 5'(len); unmasked = unm; use_scalar = vx;
    tail_agn = ta; mask_agn = ma; start = 1;
    exp = model(vd_in, src_a, src_b, scalar, elem_en, code, len, unm, vx, ta, ma);
    @(negedge clk); start = 0;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    chk("R8 done latency", cnt == n, REG_W'(cnt), REG_W'(n));
    chk(req, vd_out === exp, vd_out, exp);
    @(negedge clk);
    chk("R8 done single pulse", !done && !busy, REG_W'(done), '0);
  endtask

  task automatic t_reset();
    chk("R10 reset", vd_out == '0 && !busy && !done, vd_out, '0);
  endtask

  task automatic t_vv_all_widths();
    for (int c = 0; c < 4; c++) begin
      vd_in = rnd(); src_a = rnd(); src_b = rnd(); scalar = rnd()[63:0]; elem_en = '1;
      run("R1 R2 vector-vector", c, 16, 1, 0, 0, 0);
    end
  endtask

  task automatic t_wrap();
    vd_in = {16{8'hFF}}; src_a = {16{8'hFF}}; src_b = {16{8'hFF}};
    run("R2 wrap 8-bit", 0, 16, 1, 0, 0, 0);
    chk("R2 wrap value zero", vd_out == '0, vd_out, '0);
  endtask

  task automatic t_scalar();
    vd_in = rnd(); src_a = rnd(); src_b = rnd(); scalar = 64'hDEAD_BEEF_0000_1203;
    run("R3 scalar 16-bit", 1, 16, 1, 1, 0, 0);
    scalar = 64'hFFFF_FFFF_FFFF_FF03;
    run("R3 scalar upper bits ignored 8-bit", 0, 16, 1, 1, 0, 0);
  endtask

  task automatic t_mask();
    vd_in = rnd(); src_a = rnd(); src_b = rnd(); elem_en = 16'b0000_0000_1010_0110;
    run("R4 R5 mask undisturbed", 1, 8, 0, 0, 0, 0);
    run("R4 R5 mask agnostic", 1, 8, 0, 0, 0, 1);
    run("R4 unmasked ignores enable", 0, 16, 1, 0, 0, 1);
  endtask

  task automatic t_tail();
    vd_in = rnd(); src_a = rnd(); src_b = rnd(); elem_en = '1;
    run("R6 tail agnostic 64-bit", 3, 1, 1, 0, 1, 0);
    run("R6 tail undisturbed 32-bit", 2, 3, 1, 0, 0, 1);
  endtask

  task automatic t_vl0();
    logic [REG_W-1:0] old;
    vd_in = rnd(); src_a = rnd(); src_b = rnd(); elem_en = '0; old = vd_in;
    run("R7 vl zero", 2, 0, 0, 0, 1, 1);
    chk("R7 destination unchanged", vd_out === old, vd_out, old);
  endtask

  task automatic t_hold();
    logic [REG_W-1:0] held, exp;
    vd_in = rnd(); src_a = rnd(); src_b = rnd(); elem_en = '1;
    run("R9 setup", 2, 4, 1, 0, 0, 0);
    held = vd_out;
    vd_in = rnd(); src_a = rnd();
    repeat (5) @(negedge clk);
    chk("R9 hold while idle", vd_out === held, vd_out, held);
    // start during busy is ignored
    exp = model(vd_in, src_a, src_b, scalar, elem_en, 0, 16, 1, 0, 0, 0);
    ew = 0; vl = 16; unmasked = 1; use_scalar = 0; tail_agn = 0; mask_agn = 0; start = 1;
    @(negedge clk);
    vd_in = rnd(); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk("R9 start while busy ignored", vd_out === exp, vd_out, exp);
    @(negedge clk);
  endtask

  initial begin
    start = 0; ew = 0; vl = 0; unmasked = 1; use_scalar = 0; tail_agn = 0; mask_agn = 0;
    vd_in = '0; src_a = '0; src_b = '0; scalar = '0; elem_en = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_vv_all_widths();
    t_wrap();
    t_scalar();
    t_mask();
    t_tail();
    t_vl0();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule